// File: doc/BRIEF.md
# Tagged Address Translation Cache

A small fully associative cache of address translations. Each entry pairs a virtual page number with a physical frame number, a no-execute flag and an address-space tag. A lookup compares the requested page number against every entry in the same cycle. One clock later the block reports a hit together with the frame number and the no-execute flag, or it reports a miss. On a miss, an external agent such as software or a table walker fetches the mapping and writes it in through the refill port.

With tags enabled, a context switch only loads a new current-context value. Entries written under other contexts stay resident but stop matching. With tags disabled, a context switch clears the whole cache, and a separate flush input clears it in either mode. An update port rewrites or drops the entry for one page when its mapping changes. An instruction fetch that hits a no-execute entry raises a protection fault. Refill victims are chosen by a tree pseudo-LRU or by an 8-bit LFSR, picked by a parameter.

Top module: `xlate_cache`

## Requirements
- R1: A request on `lk_req` produces `rsp_valid` on the next clock. A hit reports the frame number and no-execute bit of the one valid entry whose page number equals `lk_vpn` and, with tags enabled, whose tag equals the current context.
- R2: A request that finds no such entry gives `rsp_miss`=1, `rsp_hit`=0, `rsp_pfn`=0 and `rsp_nx`=0. `rsp_hit` and `rsp_miss` are never both high, and without a request all response outputs are 0.
- R3: A refill goes to the lowest-numbered invalid entry. When every entry is valid, it goes to the entry chosen by the replacement policy: the pseudo-LRU tree when `USE_PLRU`=1, otherwise the low bits of an 8-bit LFSR (taps 8,6,5,4, seeded 1) that steps every cycle.
- R4: The pseudo-LRU tree (ENTRIES-1 bits, root first, bit 0 means "victim on the left") is updated on every lookup hit and then on every refill. Touching an entry points every node on its path away from it. After hits on entries 0 to 7 in that order, the next victim is entry 0.
- R5: With tags enabled, `ctx_wr` loads `ctx_id` as the current context and invalidates nothing. A refill stores the context held before that edge.
- R6: With tags disabled, `ctx_wr` invalidates every entry.
- R7: `flush_all` invalidates every entry. A refill or update in the same cycle is dropped.
- R8: The update port acts on the valid entry matching `upd_vpn` in the current context. It rewrites the frame number and no-execute bit when `upd_keep`=1 and invalidates the entry when `upd_keep`=0. With no matching entry it changes nothing.
- R9: A hit with `lk_fetch`=1 on an entry whose no-execute bit is set raises `rsp_fault` together with `rsp_hit`. A hit with `lk_fetch`=0 never faults.
- R10: A refill of a page number already valid under the same context overwrites that entry, so at most one entry ever matches.
- R11: After reset all entries are invalid, the context is 0, the tree is all zeros and every response output is 0.
- R12: A lookup sees the contents held before the edge on which it is requested. A refill takes precedence over an update in the same cycle, which is then dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_req | input | 1 | Lookup request |
| lk_vpn | input | VPN_W | Page number to translate |
| lk_fetch | input | 1 | Request is an instruction fetch |
| fill_en | input | 1 | Refill write |
| fill_vpn | input | VPN_W | Refill page number |
| fill_pfn | input | PFN_W | Refill frame number |
| fill_nx | input | 1 | Refill no-execute bit |
| upd_en | input | 1 | Update write |
| upd_keep | input | 1 | 1 rewrites the entry, 0 invalidates it |
| upd_vpn | input | VPN_W | Page number to update |
| upd_pfn | input | PFN_W | New frame number |
| upd_nx | input | 1 | New no-execute bit |
| ctx_wr | input | 1 | Context switch |
| ctx_id | input | TAG_W | New current context |
| flush_all | input | 1 | Invalidate all entries |
| rsp_valid | output | 1 | Response present |
| rsp_hit | output | 1 | Lookup hit |
| rsp_miss | output | 1 | Lookup miss, refill needed |
| rsp_pfn | output | PFN_W | Translated frame number |
| rsp_nx | output | 1 | No-execute bit of the hit entry |
| rsp_fault | output | 1 | Fetch hit a no-execute page |

## Verification
Every response is due exactly one clock after its request, and every write (refill, update, flush, context switch) takes effect at the edge on which it is presented. A lookup issued in the following cycle is therefore the first one to see that write. The bench drives inputs at the falling edge and advances a behavioural model over the same edge. It compares all response outputs 1 ns after that rising edge, so each compare sees the result of the request made in the cycle just ended. A second instance, with tags disabled and the random policy, is checked with directed lookups placed one cycle after each write.

// File: rtl/xlate_cache.sv
module xlate_cache #(
  parameter int ENTRIES  = 8,
  parameter int VPN_W    = 20,
  parameter int PFN_W    = 20,
  parameter int TAG_W    = 8,
  parameter bit USE_TAGS = 1'b1,
  parameter bit USE_PLRU = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lk_req,
  input  logic [VPN_W-1:0] lk_vpn,
  input  logic             lk_fetch,
  input  logic             fill_en,
  input  logic [VPN_W-1:0] fill_vpn,
  input  logic [PFN_W-1:0] fill_pfn,
  input  logic             fill_nx,
  input  logic             upd_en,
  input  logic             upd_keep,
  input  logic [VPN_W-1:0] upd_vpn,
  input  logic [PFN_W-1:0] upd_pfn,
  input  logic             upd_nx,
  input  logic             ctx_wr,
  input  logic [TAG_W-1:0] ctx_id,
  input  logic             flush_all,
  output logic             rsp_valid,
  output logic             rsp_hit,
  output logic             rsp_miss,
  output logic [PFN_W-1:0] rsp_pfn,
  output logic             rsp_nx,
  output logic             rsp_fault
);
  localparam int IDX_W  = $clog2(ENTRIES);
  localparam int TREE_W = ENTRIES - 1;

  logic [ENTRIES-1:0] vld, nx;
  logic [VPN_W-1:0]   vpn_q [ENTRIES];
  logic [PFN_W-1:0]   pfn_q [ENTRIES];
  logic [TAG_W-1:0]   tag_q [ENTRIES];
  logic [TAG_W-1:0]   ctx_q;

  logic [ENTRIES-1:0] tag_eq, lk_match, fl_match, up_match;
  logic [IDX_W-1:0]   lk_idx, fl_idx, up_idx, fill_idx, pol_idx;
  logic               lk_any, wipe;

  function automatic logic [IDX_W-1:0] low_idx(input logic [ENTRIES-1:0] v);
    logic [IDX_W-1:0] r;
    r = '0;
    for (int i = ENTRIES - 1; i >= 0; i--)
      if (v[i]) r = IDX_W'(i);
    return r;
  endfunction

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign tag_eq[g]   = !USE_TAGS || (tag_q[g] == ctx_q);
    assign lk_match[g] = vld[g] && tag_eq[g] && (vpn_q[g] == lk_vpn);
    assign fl_match[g] = vld[g] && tag_eq[g] && (vpn_q[g] == fill_vpn);
    assign up_match[g] = vld[g] && tag_eq[g] && (vpn_q[g] == upd_vpn);
  end

  assign lk_any = |lk_match;
  assign lk_idx = low_idx(lk_match);
  assign fl_idx = low_idx(fl_match);
  assign up_idx = low_idx(up_match);
  assign wipe   = flush_all || (ctx_wr && !USE_TAGS);

  assign fill_idx = (|fl_match) ? fl_idx :
                    (~&vld)     ? low_idx(~vld) : pol_idx;

  if (USE_PLRU) begin : g_plru
    logic [TREE_W-1:0] tree_q, tree_d;

    function automatic logic [TREE_W-1:0] touch(input logic [TREE_W-1:0] t,
                                                input logic [IDX_W-1:0] idx);
      logic [IDX_W-1:0] n;
      logic b;
      n = '0;
      for (int l = 0; l < IDX_W; l++) begin
        b    = idx[IDX_W-1-l];
        t[n] = ~b;
        n    = IDX_W'(2 * int'(n) + 1 + int'(b));
      end
      return t;
    endfunction

    function automatic logic [IDX_W-1:0] pick(input logic [TREE_W-1:0] t);
      logic [IDX_W-1:0] n, v;
      logic b;
      n = '0;
      v = '0;
      for (int l = 0; l < IDX_W; l++) begin
        b              = t[n];
        v[IDX_W-1-l]   = b;
        n              = IDX_W'(2 * int'(n) + 1 + int'(b));
      end
      return v;
    endfunction

    always_comb begin
      tree_d = tree_q;
      if (lk_req && lk_any) tree_d = touch(tree_d, lk_idx);
      if (fill_en && !wipe) tree_d = touch(tree_d, fill_idx);
    end

    always_ff @(posedge clk)
      if (!rst_n) tree_q <= '0;
      else        tree_q <= tree_d;

    assign pol_idx = pick(tree_q);
  end else begin : g_rand
    logic [7:0] lfsr_q;
    always_ff @(posedge clk)
      if (!rst_n) lfsr_q <= 8'h01;
      else        lfsr_q <= {lfsr_q[6:0], lfsr_q[7] ^ lfsr_q[5] ^ lfsr_q[4] ^ lfsr_q[3]};
    assign pol_idx = lfsr_q[IDX_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld   <= '0;
      nx    <= '0;
      ctx_q <= '0;
    end else begin
      if (wipe) begin
        vld <= '0;
      end else if (fill_en) begin
        vld[fill_idx]   <= 1'b1;
        nx[fill_idx]    <= fill_nx;
        vpn_q[fill_idx] <= fill_vpn;
        pfn_q[fill_idx] <= fill_pfn;
        tag_q[fill_idx] <= ctx_q;
      end else if (upd_en && |up_match) begin
        if (upd_keep) begin
          pfn_q[up_idx] <= upd_pfn;
          nx[up_idx]    <= upd_nx;
        end else begin
          vld[up_idx] <= 1'b0;
        end
      end
      if (ctx_wr) ctx_q <= ctx_id;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_miss  <= 1'b0;
      rsp_pfn   <= '0;
      rsp_nx    <= 1'b0;
      rsp_fault <= 1'b0;
    end else begin
      rsp_valid <= lk_req;
      rsp_hit   <= lk_req && lk_any;
      rsp_miss  <= lk_req && !lk_any;
      rsp_pfn   <= (lk_req && lk_any) ? pfn_q[lk_idx] : '0;
      rsp_nx    <= lk_req && lk_any && nx[lk_idx];
      rsp_fault <= lk_req && lk_any && nx[lk_idx] && lk_fetch;
    end
  end
endmodule

// File: rtl/xlate_cache_chk.sv
module xlate_cache_chk #(
  parameter int ENTRIES  = 8,
  parameter int PFN_W    = 20,
  parameter bit USE_TAGS = 1'b1
) (
  input logic               clk,
  input logic               rst_n,
  input logic               lk_req,
  input logic               lk_fetch,
  input logic               fill_en,
  input logic               upd_en,
  input logic               ctx_wr,
  input logic               flush_all,
  input logic               rsp_valid,
  input logic               rsp_hit,
  input logic               rsp_miss,
  input logic [PFN_W-1:0]   rsp_pfn,
  input logic               rsp_nx,
  input logic               rsp_fault,
  input logic [ENTRIES-1:0] vld,
  input logic [ENTRIES-1:0] lk_match
);
  AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    lk_req |=> (rsp_valid && (rsp_hit != rsp_miss))); // R1
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_req |=> !(rsp_valid || rsp_hit || rsp_miss || rsp_fault || rsp_nx)); // R2
  AST_MISS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_miss |-> (rsp_pfn == '0 && !rsp_nx && !rsp_fault)); // R2
  AST_FAULT_ON_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_fault |-> (rsp_hit && rsp_nx && $past(lk_fetch))); // R9
  AST_FLUSH_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    flush_all |=> (vld == '0)); // R7
  AST_UNTAGGED_SWITCH: assert property (@(posedge clk) disable iff (!rst_n)
    (ctx_wr && !USE_TAGS) |=> (vld == '0)); // R6
  AST_TAGGED_SWITCH_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (ctx_wr && USE_TAGS && !flush_all && !fill_en && !upd_en) |=> $stable(vld)); // R5
  AST_SINGLE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lk_match)); // R10
endmodule

bind xlate_cache xlate_cache_chk #(.ENTRIES(ENTRIES), .PFN_W(PFN_W), .USE_TAGS(USE_TAGS)) u_chk (
  .clk(clk), .rst_n(rst_n), .lk_req(lk_req), .lk_fetch(lk_fetch), .fill_en(fill_en),
  .upd_en(upd_en), .ctx_wr(ctx_wr), .flush_all(flush_all), .rsp_valid(rsp_valid),
  .rsp_hit(rsp_hit), .rsp_miss(rsp_miss), .rsp_pfn(rsp_pfn), .rsp_nx(rsp_nx),
  .rsp_fault(rsp_fault), .vld(vld), .lk_match(lk_match));

// File: tb/tb_xlate_cache.sv
`timescale 1ns/1ps
module tb_xlate_cache;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic        lk_req, lk_fetch, fill_en, fill_nx, upd_en, upd_keep, upd_nx, ctx_wr, flush_all;
  logic [19:0] lk_vpn, fill_vpn, fill_pfn, upd_vpn, upd_pfn;
  logic [7:0]  ctx_id;
  logic        rsp_valid, rsp_hit, rsp_miss, rsp_nx, rsp_fault;
  logic [19:0] rsp_pfn;

  xlate_cache dut (
    .clk(clk), .rst_n(rst_n), .lk_req(lk_req), .lk_vpn(lk_vpn), .lk_fetch(lk_fetch),
    .fill_en(fill_en), .fill_vpn(fill_vpn), .fill_pfn(fill_pfn), .fill_nx(fill_nx),
    .upd_en(upd_en), .upd_keep(upd_keep), .upd_vpn(upd_vpn), .upd_pfn(upd_pfn), .upd_nx(upd_nx),
    .ctx_wr(ctx_wr), .ctx_id(ctx_id), .flush_all(flush_all),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_miss(rsp_miss), .rsp_pfn(rsp_pfn),
    .rsp_nx(rsp_nx), .rsp_fault(rsp_fault));

  logic        n_req, n_fill, n_ctx, n_hit, n_valid, n_miss, n_nx, n_fault;
  logic [19:0] n_vpn, n_pfn;

  xlate_cache #(.USE_TAGS(1'b0), .USE_PLRU(1'b0)) dut_nt (
    .clk(clk), .rst_n(rst_n), .lk_req(n_req), .lk_vpn(n_vpn), .lk_fetch(1'b0),
    .fill_en(n_fill), .fill_vpn(n_vpn), .fill_pfn(20'h00100 + n_vpn), .fill_nx(1'b0),
    .upd_en(1'b0), .upd_keep(1'b0), .upd_vpn(20'h0), .upd_pfn(20'h0), .upd_nx(1'b0),
    .ctx_wr(n_ctx), .ctx_id(8'h3), .flush_all(1'b0),
    .rsp_valid(n_valid), .rsp_hit(n_hit), .rsp_miss(n_miss), .rsp_pfn(n_pfn),
    .rsp_nx(n_nx), .rsp_fault(n_fault));

  int checks = 0, fails = 0;
  bit done = 0;

  bit mv[8], mnx[8];
  int mvpn[8], mpfn[8], mtag[8];
  int mctx;
  bit mt[7];

  task automatic check(string req, bit ok, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle();
    lk_req = 0; lk_vpn = 0; lk_fetch = 0; fill_en = 0; fill_vpn = 0; fill_pfn = 0; fill_nx = 0;
    upd_en = 0; upd_keep = 0; upd_vpn = 0; upd_pfn = 0; upd_nx = 0; ctx_wr = 0; ctx_id = 0;
    flush_all = 0;
  endtask

  function automatic int model_victim();
    int n = 0, v = 0;
    for (int l = 0; l < 3; l++) begin
      int b = mt[n];
      v = v * 2 + b;
      n = 2 * n + 1 + b;
    end
    return v;
  endfunction

  task automatic model_touch(int idx);
    int n = 0;
    for (int l = 0; l < 3; l++) begin
      int b = (idx >> (2 - l)) & 1;
      mt[n] = (b == 0);
      n = 2 * n + 1 + b;
    end
  endtask

  // advance model over one edge with current inputs, then compare outputs
  task automatic tick(string req);
    int hit = -1, tgt = -1, upi = -1, vic;
    logic [24:0] exp_v, act_v;
    bit wipe;
    vic = model_victim();
    for (int i = 0; i < 8; i++)
      if (mv[i] && mvpn[i] == int'(lk_vpn) && mtag[i] == mctx && hit < 0) hit = i;
    if (lk_req && hit >= 0)
      exp_v = {1'b1, 1'b1, 1'b0, mnx[hit] & lk_fetch, mnx[hit], mpfn[hit][19:0]};
    else if (lk_req)
      exp_v = {1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 20'h0};
    else
      exp_v = '0;
    wipe = flush_all;
    if (fill_en) begin
      for (int i = 0; i < 8; i++)
        if (mv[i] && mvpn[i] == int'(fill_vpn) && mtag[i] == mctx && tgt < 0) tgt = i;
      for (int i = 0; i < 8; i++)
        if (!mv[i] && tgt < 0) tgt = i;
      if (tgt < 0) tgt = vic;
    end
    if (lk_req && hit >= 0) model_touch(hit);
    if (fill_en && !wipe) model_touch(tgt);
    if (wipe) begin
      for (int i = 0; i < 8; i++) mv[i] = 0;
    end else if (fill_en) begin
      mv[tgt] = 1; mvpn[tgt] = int'(fill_vpn); mpfn[tgt] = int'(fill_pfn);
      mnx[tgt] = fill_nx; mtag[tgt] = mctx;
    end else if (upd_en) begin
      for (int i = 0; i < 8; i++)
        if (mv[i] && mvpn[i] == int'(upd_vpn) && mtag[i] == mctx && upi < 0) upi = i;
      if (upi >= 0) begin
        if (upd_keep) begin mpfn[upi] = int'(upd_pfn); mnx[upi] = upd_nx; end
        else mv[upi] = 0;
      end
    end
    if (ctx_wr) mctx = int'(ctx_id);
    @(posedge clk); #1;
    act_v = {rsp_valid, rsp_hit, rsp_miss, rsp_fault, rsp_nx, rsp_pfn};
    check(req, act_v === exp_v, 64'(act_v), 64'(exp_v));
    @(negedge clk);
    idle();
  endtask

  task automatic look(int vpn, bit fetch, string req);
    lk_req = 1; lk_vpn = 20'(vpn); lk_fetch = fetch; tick(req);
  endtask

  task automatic fill(int vpn, int pfn, bit x, string req);
    fill_en = 1; fill_vpn = 20'(vpn); fill_pfn = 20'(pfn); fill_nx = x; tick(req);
  endtask

  task automatic nt_step(bit rq, bit fl, bit cx, int vpn);
    n_req = rq; n_fill = fl; n_ctx = cx; n_vpn = 20'(vpn);
    @(posedge clk); #1;
    @(negedge clk);
    n_req = 0; n_fill = 0; n_ctx = 0;
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    int hits;
    idle();
    n_req = 0; n_fill = 0; n_ctx = 0; n_vpn = 0;
    for (int i = 0; i < 8; i++) begin mv[i] = 0; mnx[i] = 0; end
    for (int i = 0; i < 7; i++) mt[i] = 0;
    mctx = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    #1;
    check("R11 reset outputs", {rsp_valid, rsp_hit, rsp_miss, rsp_fault, rsp_nx, rsp_pfn} == '0,
          64'({rsp_valid, rsp_hit, rsp_miss, rsp_pfn}), 64'h0);

    look(20'h12345, 0, "R2 miss on empty");
    fill(20'h12345, 20'hABCDE, 0, "R3 refill first invalid");
    look(20'h12345, 0, "R1 hit returns frame");
    look(20'h12346, 0, "R2 neighbour page misses");
    fill(20'h12345, 20'h0F0F0, 0, "R10 duplicate refill overwrites");
    look(20'h12345, 1, "R10 overwritten frame seen");

    fill(20'h00777, 20'h55555, 1, "R9 refill no-exec page");
    look(20'h00777, 1, "R9 fetch on no-exec faults");
    look(20'h00777, 0, "R9 data access no fault");

    flush_all = 1; fill_en = 1; fill_vpn = 20'h00001; fill_pfn = 20'h1; tick("R7 flush drops same-cycle refill");
    look(20'h12345, 0, "R7 flushed entry misses");
    look(20'h00001, 0, "R7 dropped refill absent");

    for (int i = 0; i < 8; i++) fill(i, 20'h100 + i, 0, "R3 fill to full");
    for (int i = 0; i < 8; i++) look(i, 0, "R4 touch in order");
    fill(20'h00020, 20'h00999, 0, "R4 plru victim refill");
    look(0, 0, "R4 entry 0 evicted");
    look(1, 0, "R4 entry 1 kept");
    begin
      @(negedge clk);
    end
    lk_req = 1; lk_vpn = 20'h00020; fill_en = 1; fill_vpn = 20'h00020; fill_pfn = 20'h00AAA;
    tick("R12 lookup sees pre-edge frame");
    look(20'h00020, 0, "R12 new frame after edge");
    fill_en = 1; fill_vpn = 20'h00030; fill_pfn = 20'h333; upd_en = 1; upd_keep = 1; upd_vpn = 20'h00002;
    upd_pfn = 20'h00BBB; tick("R12 refill wins over update");
    look(2, 0, "R12 update dropped");

    upd_en = 1; upd_keep = 1; upd_vpn = 20'h3; upd_pfn = 20'h7777; upd_nx = 1; tick("R8 rewrite entry");
    look(3, 1, "R8 rewritten frame and nx");
    upd_en = 1; upd_keep = 0; upd_vpn = 20'h4; tick("R8 invalidate entry");
    look(4, 0, "R8 invalidated entry misses");
    upd_en = 1; upd_keep = 1; upd_vpn = 20'h0FFFF; upd_pfn = 20'h1; tick("R8 no-match update");
    look(5, 0, "R8 no-match leaves others");

    ctx_wr = 1; ctx_id = 8'h05; tick("R5 context switch");
    look(5, 0, "R5 other context misses");
    fill(5, 20'h05005, 0, "R5 refill under new context");
    look(5, 0, "R5 new context hits");
    ctx_wr = 1; ctx_id = 8'h00; tick("R5 switch back");
    look(5, 0, "R5 old entry survives switch");
    look(6, 0, "R5 old entry survives switch");

    for (int c = 0; c < 600; c++) begin
      int r = int'($urandom_range(0, 99));
      lk_req = ($urandom_range(0, 1) == 1);
      lk_vpn = 20'($urandom_range(0, 11));
      lk_fetch = ($urandom_range(0, 1) == 1);
      fill_en = (r < 20);
      fill_vpn = 20'($urandom_range(0, 11));
      fill_pfn = 20'($urandom);
      fill_nx = ($urandom_range(0, 3) == 0);
      upd_en = (r >= 20 && r < 35) || (r == 99);
      upd_keep = ($urandom_range(0, 2) != 0);
      upd_vpn = 20'($urandom_range(0, 11));
      upd_pfn = 20'($urandom);
      upd_nx = ($urandom_range(0, 1) == 1);
      ctx_wr = (r >= 35 && r < 40);
      ctx_id = 8'($urandom_range(0, 2));
      flush_all = (r >= 40 && r < 42);
      tick("R1 R3 R4 R12 mixed traffic");
    end

    hits = 0;
    for (int i = 0; i < 9; i++) nt_step(0, 1, 0, i);
    for (int i = 0; i < 9; i++) begin
      nt_step(1, 0, 0, i);
      if (n_hit) hits++;
    end
    check("R3 random policy keeps 8 of 9", hits == 8, 64'(hits), 64'd8);
    nt_step(0, 0, 1, 0);
    hits = 0;
    for (int i = 0; i < 9; i++) begin
      nt_step(1, 0, 0, i);
      if (n_hit) hits++;
      if (i == 0) check("R6 miss flag after untagged switch", n_miss === 1'b1, 64'(n_miss), 64'd1);
    end
    check("R6 untagged switch clears all", hits == 0, 64'(hits), 64'd0);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule